// File: doc/BRIEF.md
# Serial-Programmed Crosspoint Controller

This block is the digital control path of a routing matrix with sixteen outputs and sixteen inputs. A host loads an 80-bit control word one bit at a time: the bit on the serial data pin is taken on each falling edge of the serial clock. The bit that falls off the far end of the shift chain is presented on a serial output, so several of these blocks can be chained and loaded from one stream. A transfer strobe moves the shift chain contents into a parallel latch. Each output has a 5-bit field in that latch, and a decoder turns the field into a one-hot input select and an output enable.

A behavioural digital matrix routes a data word from the selected input to each enabled output. A disabled output drives zero and has its enable low. The enable plays the role of a tri-state control. An active-low chip select gates both shifting and transfer. An active-low reset turns every output off.

All control pins are sampled by a fast system clock `clk`. A serial-clock fall is seen as a change from high to low between two samples. Reset is synchronous to `clk` for the latch. Its effect on the outputs is immediate.

Top module: `xbar_serial_ctrl`

## Requirements
- R1: The control word is 80 bits, one 5-bit field per output. Output k's field is word bits [5k+4:5k]. The first bit shifted in ends up in bit 79 (output 15, field bit 4), and the last bit shifted in ends up in bit 0 (output 0, field bit 0).
- R2: The shift chain advances by one bit only in the `clk` cycle that follows a high-to-low change of `ser_clk`, and only while `chip_sel_n` is low. A falling edge while `chip_sel_n` is high leaves the chain unchanged.
- R3: `ser_dout` shows word bit 79. A bit entered on fall n therefore appears on `ser_dout` after fall n+79, and a chained device that samples on its own falls receives it on fall n+80.
- R4: While `chip_sel_n` and `xfer_n` are both low, the latch is transparent. The decoders follow the shift chain in the same `clk` cycle.
- R5: While `xfer_n` or `chip_sel_n` is high, the decoders keep the word that was present when the latch last closed, even if new bits are shifted in.
- R6: In each field, bits [3:0] give the input index and bit 4 is the enable (1 = driven). An enabled output carries `in_data` of the selected input. A disabled output carries zero.
- R7: `out_sel` holds 16 bits per output (bit i = input i). These bits are one-hot when the output is enabled and all zero when it is disabled.
- R8: While `rst_n` is low, every `out_en` bit is 0. Reset clears the enable bits of the latch, so outputs stay off after release until a transfer. Reset does not change the shift chain.
- R9: The matrix is non-blocking: any number of outputs may select the same input at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock sampling all control pins |
| rst_n | input | 1 | Active-low reset, disables all outputs |
| ser_clk | input | 1 | Serial shift clock, falling edge active |
| ser_din | input | 1 | Serial control data in |
| chip_sel_n | input | 1 | Active-low chip select for shift and transfer |
| xfer_n | input | 1 | Transfer strobe, low = transparent, high = hold |
| in_data | input | 128 | Sixteen 8-bit input words, input i at [8i+7:8i] |
| ser_dout | output | 1 | Serial data out for chaining |
| out_en | output | 16 | Per-output enable |
| out_sel | output | 256 | Per-output one-hot input select, output k at [16k+15:16k] |
| out_data | output | 128 | Sixteen 8-bit output words, output k at [8k+7:8k] |

## Verification
The hardest state to reach is a shift chain that differs from the latch while the ignored paths are exercised. Serial-clock falls with the chip deselected must not change the chain. A reset with the strobe held high must not touch the chain either. Neither effect shows on the outputs until a later transfer opens the latch. The stimulus therefore first makes the chain and the latch hold different words. It then applies the stimulus that should be ignored, and only afterwards opens the latch to expose the chain. Chaining is checked by shifting a second word while comparing `ser_dout` bit by bit against the first word.

// File: rtl/xbar_pkg.sv
// Shared defaults and field-position helper for the serial crosspoint controller.
// Assumes every output field is SEL_W select bits topped by one enable bit.
package xbar_pkg;
    localparam int unsigned DEF_SEL_W  = 4;
    localparam int unsigned DEF_N_OUT  = 16;
    localparam int unsigned DEF_DATA_W = 8;

    // Lowest bit position of output k's field in the control word.
    function automatic int unsigned field_lsb(int unsigned k, int unsigned fw);
        return k * fw;
    endfunction
endpackage

// File: rtl/xbar_shift_chain.sv
// Serial shift chain: detects falling edges of ser_clk by sampling with clk
// and shifts ser_din in at bit 0 while chip_sel_n is low.
// Assumes ser_clk stays at each level for at least one clk period.
// The chain itself is never reset.
module xbar_shift_chain #(
    parameter int unsigned WORD_W = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_din,
    input  logic              chip_sel_n,
    output logic [WORD_W-1:0] chain_o,
    output logic              ser_dout
);
    logic              sclk_q;
    logic              fall;
    logic [WORD_W-1:0] chain_q;

    assign fall = sclk_q & ~ser_clk;

    // Remember the previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= ser_clk;
    end

    // Shift one bit per detected fall while selected.
    always_ff @(posedge clk) begin
        if (fall && !chip_sel_n) chain_q <= {chain_q[WORD_W-2:0], ser_din};
    end

    assign chain_o  = chain_q;
    assign ser_dout = chain_q[WORD_W-1];

    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && !chip_sel_n) |=> chain_q[0] == $past(ser_din)); // R2
    AST_DESELECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        chip_sel_n |=> $stable(chain_q)); // R2
    AST_NO_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(chain_q)); // R2
    AST_CHAIN_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && !chip_sel_n) |=> ser_dout == $past(chain_q[WORD_W-2])); // R3
endmodule

// File: rtl/xbar_xfer_latch.sv
// Transfer latch: transparent while chip_sel_n and xfer_n are both low, so the
// word seen downstream is the shift chain itself; otherwise it holds the value
// captured in the last open cycle. Reset clears only the enable bits.
module xbar_xfer_latch #(
    parameter int unsigned N_OUT = 16,
    parameter int unsigned SEL_W = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           chip_sel_n,
    input  logic                           xfer_n,
    input  logic [N_OUT*(SEL_W+1)-1:0]     chain_i,
    output logic [N_OUT*(SEL_W+1)-1:0]     word_o
);
    localparam int unsigned FW = SEL_W + 1;
    localparam int unsigned WW = N_OUT * FW;

    logic          open_w;
    logic [WW-1:0] latch_q;
    logic [WW-1:0] en_mask;

    // Mark the enable bit of every field.
    for (genvar k = 0; k < N_OUT; k++) begin : g_mask
        assign en_mask[xbar_pkg::field_lsb(k, FW) +: FW] = {1'b1, {SEL_W{1'b0}}};
    end

    assign open_w = !chip_sel_n && !xfer_n;

    // Clear enables on reset, otherwise track the chain while open.
    always_ff @(posedge clk) begin
        if (!rst_n)      latch_q <= latch_q & ~en_mask;
        else if (open_w) latch_q <= chain_i;
    end

    assign word_o = open_w ? chain_i : latch_q;

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_sel_n || xfer_n) |=> $stable(latch_q)); // R5
    AST_LATCH_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_sel_n && !xfer_n) |=> latch_q == $past(chain_i)); // R4
    AST_RESET_CLEARS_EN: assert property (@(posedge clk)
        !rst_n |=> (latch_q & en_mask) == '0); // R8
endmodule

// File: rtl/xbar_out_decode.sv
// Per-output decoder: turns one field into an enable and a one-hot select.
// Assumes the field is {enable, index}; reset forces the output off.
module xbar_out_decode #(
    parameter int unsigned SEL_W = 4
) (
    input  logic                  rst_n,
    input  logic [SEL_W:0]        field_i,
    output logic [(1<<SEL_W)-1:0] sel_oh_o,
    output logic                  en_o
);
    localparam int unsigned N_IN = 1 << SEL_W;

    assign en_o = field_i[SEL_W] & rst_n;

    // Place a single one at the selected index when enabled.
    always_comb begin
        sel_oh_o = '0;
        if (en_o) sel_oh_o = {{(N_IN-1){1'b0}}, 1'b1} << field_i[SEL_W-1:0];
    end
endmodule

// File: rtl/xbar_route.sv
// Behavioural routing matrix: each output ORs the inputs picked by its
// one-hot select, so an all-zero select yields zero data.
module xbar_route #(
    parameter int unsigned N_IN   = 16,
    parameter int unsigned N_OUT  = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic [N_IN*DATA_W-1:0]  in_data,
    input  logic [N_OUT*N_IN-1:0]   sel_oh,
    output logic [N_OUT*DATA_W-1:0] out_data
);
    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        logic [DATA_W-1:0] acc;
        // AND-OR gather of the selected input word.
        always_comb begin
            acc = '0;
            for (int i = 0; i < N_IN; i++) begin
                if (sel_oh[k*N_IN + i]) acc = acc | in_data[i*DATA_W +: DATA_W];
            end
        end
        assign out_data[k*DATA_W +: DATA_W] = acc;
    end
endmodule

// File: rtl/xbar_serial_ctrl.sv
// Top of the serial-programmed crosspoint controller: shift chain, transfer
// latch, one decoder per output and the routing matrix. All control pins are
// sampled with clk; reset is synchronous for the latch and gates enables at once.
module xbar_serial_ctrl #(
    parameter int unsigned SEL_W  = xbar_pkg::DEF_SEL_W,
    parameter int unsigned N_OUT  = xbar_pkg::DEF_N_OUT,
    parameter int unsigned DATA_W = xbar_pkg::DEF_DATA_W
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                ser_clk,
    input  logic                                ser_din,
    input  logic                                chip_sel_n,
    input  logic                                xfer_n,
    input  logic [(1<<SEL_W)*DATA_W-1:0]        in_data,
    output logic                                ser_dout,
    output logic [N_OUT-1:0]                    out_en,
    output logic [N_OUT*(1<<SEL_W)-1:0]         out_sel,
    output logic [N_OUT*DATA_W-1:0]             out_data
);
    localparam int unsigned N_IN = 1 << SEL_W;
    localparam int unsigned FW   = SEL_W + 1;
    localparam int unsigned WW   = N_OUT * FW;

    logic [WW-1:0] chain;
    logic [WW-1:0] word;

    xbar_shift_chain #(.WORD_W(WW)) u_chain (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
        .chip_sel_n(chip_sel_n), .chain_o(chain), .ser_dout(ser_dout)
    );

    xbar_xfer_latch #(.N_OUT(N_OUT), .SEL_W(SEL_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .xfer_n(xfer_n),
        .chain_i(chain), .word_o(word)
    );

    for (genvar k = 0; k < N_OUT; k++) begin : g_dec
        localparam int unsigned LSB = xbar_pkg::field_lsb(k, FW);
        xbar_out_decode #(.SEL_W(SEL_W)) u_dec (
            .rst_n(rst_n), .field_i(word[LSB +: FW]),
            .sel_oh_o(out_sel[k*N_IN +: N_IN]), .en_o(out_en[k])
        );

        AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
            out_en[k] |-> $onehot(out_sel[k*N_IN +: N_IN])); // R7
        AST_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            !out_en[k] |-> out_sel[k*N_IN +: N_IN] == '0); // R7
        AST_ROUTE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            out_en[k] |-> out_data[k*DATA_W +: DATA_W] ==
                in_data[word[LSB +: SEL_W]*DATA_W +: DATA_W]); // R6
    end

    xbar_route #(.N_IN(N_IN), .N_OUT(N_OUT), .DATA_W(DATA_W)) u_route (
        .in_data(in_data), .sel_oh(out_sel), .out_data(out_data)
    );

    AST_RESET_ALL_OFF: assert property (@(posedge clk)
        !rst_n |-> out_en == '0); // R8
endmodule

// File: tb/test_xbar_serial_ctrl.sv
// Bench: loads several words in patterns, checks chaining, hold, transparency,
// deselect and reset behaviour against expectations computed from the rules.
module test_xbar_serial_ctrl;
    localparam int NO = 16;
    localparam int NI = 16;
    localparam int DW = 8;
    localparam int WW = 80;

    logic clk = 1'b0;
    logic rst_n, ser_clk, ser_din, chip_sel_n, xfer_n;
    logic [NI*DW-1:0] in_data;
    logic ser_dout;
    logic [NO-1:0] out_en;
    logic [NO*NI-1:0] out_sel;
    logic [NO*DW-1:0] out_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [WW-1:0] model;

    always #5 clk = ~clk;

    xbar_serial_ctrl i_xbar_serial_ctrl (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
        .chip_sel_n(chip_sel_n), .xfer_n(xfer_n), .in_data(in_data),
        .ser_dout(ser_dout), .out_en(out_en), .out_sel(out_sel), .out_data(out_data)
    );

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    // Input pattern p: input i carries (17i + 29p + 3) mod 256.
    task automatic set_inputs(int p);
        for (int i = 0; i < NI; i++) in_data[i*DW +: DW] = DW'(i*17 + p*29 + 3);
    endtask

    // Word kinds: sel index and enable per output, computed arithmetically.
    function automatic logic [WW-1:0] mk(int kind);
        logic [WW-1:0] w = '0;
        for (int k = 0; k < NO; k++) begin
            int s; bit e;
            case (kind)
                0: begin s = (3*k + 1) % 16; e = (k != 5); end
                1: begin s = 15 - k;         e = (k % 2 == 0); end
                2: begin s = 7;              e = 1'b1; end
                3: begin s = k;              e = 1'b1; end
                default: begin s = (k*k + 2) % 16; e = (k % 3 != 0); end
            endcase
            w[k*5 +: 5] = {e, 4'(s)};
        end
        return w;
    endfunction

    // One serial bit: high phase then low phase, two clk periods each.
    task automatic shift_bit(logic b);
        ser_din = b; ser_clk = 1'b1;
        step(2);
        ser_clk = 1'b0;
        step(2);
        if (!chip_sel_n) model = {model[WW-2:0], b};
    endtask

    task automatic send_word(logic [WW-1:0] w);
        for (int i = WW-1; i >= 0; i--) shift_bit(w[i]);
    endtask

    // Compare every output against word w (R1, R6, R7); rst gates enables (R8).
    task automatic check_word(logic [WW-1:0] w, string req);
        for (int k = 0; k < NO; k++) begin
            logic [4:0] f = w[k*5 +: 5];
            bit e = f[4] & rst_n;
            logic [NI-1:0] exp_oh = e ? (NI'(1) << f[3:0]) : '0;
            logic [DW-1:0] exp_d  = e ? in_data[f[3:0]*DW +: DW] : '0;
            chk(out_en[k] == e, req, $sformatf("R6 out_en[%0d]", k), 32'(out_en[k]), 32'(e));
            chk(out_sel[k*NI +: NI] == exp_oh, req, $sformatf("R7 out_sel[%0d]", k),
                32'(out_sel[k*NI +: NI]), 32'(exp_oh));
            chk(out_data[k*DW +: DW] == exp_d, req, $sformatf("R6 out_data[%0d]", k),
                32'(out_data[k*DW +: DW]), 32'(exp_d));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ser_clk = 1'b0; ser_din = 1'b0; chip_sel_n = 1'b1; xfer_n = 1'b1;
        model = '0;
        set_inputs(0);
        step(4);
        // R8: all outputs off during reset.
        check_word('0, "R8 reset");
        rst_n = 1'b1;
        step(2);
        check_word('0, "R8 after release");

        // Load A with strobe held: outputs stay off (R5).
        chip_sel_n = 1'b0;
        send_word(mk(0));
        check_word('0, "R5 hold during load");

        // Load B while watching the chained output carry A (R3).
        begin
            logic [WW-1:0] wa = mk(0);
            logic [WW-1:0] wb = mk(1);
            for (int i = WW-1; i >= 0; i--) begin
                chk(ser_dout == wa[i], "R3", $sformatf("ser_dout bit %0d", i),
                    32'(ser_dout), 32'(wa[i]));
                shift_bit(wb[i]);
            end
        end

        // Strobe pulse transfers B (R1, R4), swept over input patterns.
        xfer_n = 1'b0; step(1); xfer_n = 1'b1; step(1);
        for (int p = 0; p < 4; p++) begin
            set_inputs(p); step(1);
            check_word(mk(1), "R1 R4 transfer");
        end

        // Shift C with strobe high: outputs keep B (R5).
        send_word(mk(2));
        check_word(mk(1), "R5 hold while shifting");

        // Deselect, open strobe: latch must still hold B (R5).
        chip_sel_n = 1'b1; xfer_n = 1'b0; step(2);
        check_word(mk(1), "R5 deselect holds");

        // Falls while deselected are ignored (R2); chain still holds C.
        send_word(mk(3));
        chip_sel_n = 1'b0; step(1);
        // R2 and R9: C routes input 7 to every output.
        check_word(model, "R2 R9 ignored shifts");
        check_word(mk(2), "R9 shared input");

        // Transparent sweep: decoders follow each shifted bit (R4).
        begin
            logic [WW-1:0] we = mk(4);
            for (int i = WW-1; i >= 0; i--) begin
                shift_bit(we[i]);
                check_word(model, "R4 transparent");
            end
        end

        // Close the latch, then reset: enables cleared, chain kept (R8).
        xfer_n = 1'b1; step(1);
        rst_n = 1'b0; step(2);
        check_word('0, "R8 reset pulse");
        rst_n = 1'b1; step(2);
        check_word('0, "R8 off after release");
        xfer_n = 1'b0; step(1);
        check_word(mk(4), "R8 chain kept");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule